// File: doc/BRIEF.md
# Operand Hazard and Forwarding Unit

This unit resolves read-after-write data hazards for a five-stage in-order 32-bit pipeline (fetch, operand read, execute, memory, write-back). Each cycle it takes the register specifiers of the instruction in the operand-read stage. It compares them with the instructions that are still in flight in the execute, memory and write-back stages. For each of the two operands it chooses where the value comes from: the register file read port or one of the three later stages. It also drives the two 32-bit operand multiplexers that deliver the chosen values.

The unit keeps a small record for each in-flight instruction. The record holds whether the instruction writes a register, which register it writes, and its write-data selection. Each clock the records move one stage down the pipe. When the operand-read stage stalls, an empty record enters the execute stage in place of an instruction. The unit also selects the value each later stage can forward: the saved return address (PC+4) or the ALU result. It forms the final write-back data from a four-way choice. When a needed operand is being loaded from memory and the data cannot exist yet, the unit raises a stall. This stall holds the fetch and operand-read registers outside the unit.

Top module: `hazard_bypass_unit`

## Requirements
- R1: The operand-read instruction bits are given on `rf_ir[25:11]`. The destination is bits 25:21, the first source is bits 20:16 and the second source is bits 15:11. When `rf_store_sel` is 1, the second operand uses bits 25:21 in place of bits 15:11.
- R2: A source equal to register 31 always gets select 0 and never causes a stall, whatever the in-flight instructions write.
- R3: `sel_a` and `sel_b` use this encoding: 0 = register file read data, 1 = write-back data, 2 = memory-stage value, 3 = execute-stage value. `op_a` and `op_b` deliver the value that their select names.
- R4: When more than one stage writes the same source register, the youngest writer wins. Execute beats memory, and memory beats write-back.
- R5: The execute-stage and memory-stage forwarded values are chosen by bit 0 of that stage's write-data select. A 0 gives the stage's PC+4 and a 1 gives the stage's ALU result.
- R6: `wb_wdata` follows the write-back stage's 2-bit write-data select: 0 = PC+4, 1 = ALU result, 2 = memory read data, 3 = zero. This same value is what select 1 forwards.
- R7: An instruction becomes a producer only when `rf_reg_wr` is 1 in the cycle it leaves the operand-read stage. Its record then reaches execute, memory and write-back on the next three clock edges. In write-back the record drives `wb_we` and `wb_dst`.
- R8: `stall` is raised in the same cycle when the stage chosen for either operand is execute or memory and bit 1 of that stage's write-data select is set (a load). A load that has reached write-back is forwarded without a stall.
- R9: In a cycle with `stall` high, the record that enters the execute stage at the next edge is empty. No operand can then select the execute stage in the following cycle.
- R10: `stall` is 0 while `rst` is high. A clock edge with `rst` high clears all in-flight records, so afterwards every select is 0 until new producers enter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_ir | input | 15 | Instruction bits 25:11 of the operand-read stage |
| rf_store_sel | input | 1 | Second operand reads the destination field (stores) |
| rf_reg_wr | input | 1 | Operand-read instruction writes the register file |
| rf_wdsel | input | 2 | Write-data select of the operand-read instruction |
| rf_rd1 | input | 32 | Register file read data, first operand |
| rf_rd2 | input | 32 | Register file read data, second operand |
| alu_pc4 | input | 32 | PC+4 held in the execute stage |
| alu_res | input | 32 | ALU result of the execute stage |
| mem_pc4 | input | 32 | PC+4 held in the memory stage |
| mem_res | input | 32 | ALU result held in the memory stage |
| wb_pc4 | input | 32 | PC+4 held in the write-back stage |
| wb_res | input | 32 | ALU result held in the write-back stage |
| wb_mrd | input | 32 | Memory read data in the write-back stage |
| stall | output | 1 | Hold fetch and operand-read; bubble into execute |
| sel_a | output | 2 | Forwarding select, first operand |
| sel_b | output | 2 | Forwarding select, second operand |
| op_a | output | 32 | First operand after forwarding |
| op_b | output | 32 | Second operand after forwarding |
| wb_wdata | output | 32 | Final register write data |
| wb_we | output | 1 | Write-back stage writes the register file |
| wb_dst | output | 5 | Register written by the write-back stage |

## Verification
Priority and the load stall can meet in the same cycle. For example, a non-load in execute may write the same register that a load in memory writes, so the younger result must be forwarded with no stall. The reverse order must stall. A stall and a register-31 match can also coincide, as can a store whose destination field collides with a load in flight. The bench draws specifiers from a small pool of registers that includes register 31, which makes such overlaps frequent. A behavioural queue of in-flight records predicts the selects, operands, write-back outputs and stall each cycle, with a reset pulse in mid-run.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int REG_AW   = 5;
    localparam int NUM_OPS  = 2;
    localparam logic [REG_AW-1:0] ZERO_REG = 5'd31;

    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_WB  = 2'd1,
        FWD_MEM = 2'd2,
        FWD_ALU = 2'd3
    } fwd_src_e;

    // Write-data select codes of an in-flight instruction
    localparam logic [1:0] WD_PC4  = 2'd0;
    localparam logic [1:0] WD_ALU  = 2'd1;
    localparam logic [1:0] WD_MEM  = 2'd2;
    localparam logic [1:0] WD_ZERO = 2'd3;

    // Record of one in-flight instruction
    typedef struct packed {
        logic              wr;
        logic [REG_AW-1:0] dst;
        logic [1:0]        wdsel;
    } prod_t;

    localparam prod_t PROD_NONE = '{wr: 1'b0, dst: '0, wdsel: 2'b00};

    function automatic logic writes_reg(prod_t t, logic [REG_AW-1:0] r);
        return t.wr && (t.dst == r) && (r != ZERO_REG);
    endfunction

    function automatic logic is_load(prod_t t);
        return t.wdsel[1];
    endfunction

endpackage

// File: rtl/hz_tag_pipe.sv
module hz_tag_pipe
    import hz_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stall,
    input  prod_t rf_tag,
    output prod_t alu_tag,
    output prod_t mem_tag,
    output prod_t wb_tag
);

    prod_t enter_tag;

    always_comb begin
        enter_tag = rf_tag;
        if (stall || !rf_tag.wr)
            enter_tag = PROD_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alu_tag <= PROD_NONE;
            mem_tag <= PROD_NONE;
            wb_tag  <= PROD_NONE;
        end else begin
            alu_tag <= enter_tag;
            mem_tag <= alu_tag;
            wb_tag  <= mem_tag;
        end
    end

endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
(
    input  logic [REG_AW-1:0] src,
    input  prod_t             alu_tag,
    input  prod_t             mem_tag,
    input  prod_t             wb_tag,
    output fwd_src_e          sel,
    output logic              load_wait
);

    // Youngest writer first: execute, then memory, then write-back
    always_comb begin
        sel       = FWD_RF;
        load_wait = 1'b0;
        if (writes_reg(alu_tag, src)) begin
            sel       = FWD_ALU;
            load_wait = is_load(alu_tag);
        end else if (writes_reg(mem_tag, src)) begin
            sel       = FWD_MEM;
            load_wait = is_load(mem_tag);
        end else if (writes_reg(wb_tag, src)) begin
            sel       = FWD_WB;
        end
    end

endmodule

// File: rtl/hz_stage_vals.sv
module hz_stage_vals
    import hz_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  prod_t            alu_tag,
    input  prod_t            mem_tag,
    input  prod_t            wb_tag,
    input  logic [XLEN-1:0]  alu_pc4,
    input  logic [XLEN-1:0]  alu_res,
    input  logic [XLEN-1:0]  mem_pc4,
    input  logic [XLEN-1:0]  mem_res,
    input  logic [XLEN-1:0]  wb_pc4,
    input  logic [XLEN-1:0]  wb_res,
    input  logic [XLEN-1:0]  wb_mrd,
    output logic [XLEN-1:0]  alu_fv,
    output logic [XLEN-1:0]  mem_fv,
    output logic [XLEN-1:0]  wb_fv
);

    assign alu_fv = alu_tag.wdsel[0] ? alu_res : alu_pc4;
    assign mem_fv = mem_tag.wdsel[0] ? mem_res : mem_pc4;

    always_comb begin
        unique case (wb_tag.wdsel)
            WD_PC4:  wb_fv = wb_pc4;
            WD_ALU:  wb_fv = wb_res;
            WD_MEM:  wb_fv = wb_mrd;
            WD_ZERO: wb_fv = '0;
            default: wb_fv = '0;
        endcase
    end

endmodule

// File: rtl/hazard_bypass_unit.sv
module hazard_bypass_unit
    import hz_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [25:11]     rf_ir,
    input  logic             rf_store_sel,
    input  logic             rf_reg_wr,
    input  logic [1:0]       rf_wdsel,
    input  logic [XLEN-1:0]  rf_rd1,
    input  logic [XLEN-1:0]  rf_rd2,
    input  logic [XLEN-1:0]  alu_pc4,
    input  logic [XLEN-1:0]  alu_res,
    input  logic [XLEN-1:0]  mem_pc4,
    input  logic [XLEN-1:0]  mem_res,
    input  logic [XLEN-1:0]  wb_pc4,
    input  logic [XLEN-1:0]  wb_res,
    input  logic [XLEN-1:0]  wb_mrd,
    output logic             stall,
    output logic [1:0]       sel_a,
    output logic [1:0]       sel_b,
    output logic [XLEN-1:0]  op_a,
    output logic [XLEN-1:0]  op_b,
    output logic [XLEN-1:0]  wb_wdata,
    output logic             wb_we,
    output logic [4:0]       wb_dst
);

    prod_t rf_tag, alu_tag, mem_tag, wb_tag;
    logic [XLEN-1:0]   alu_fv, mem_fv, wb_fv;
    logic [REG_AW-1:0] src    [NUM_OPS];
    logic [XLEN-1:0]   rd_val [NUM_OPS];
    logic [XLEN-1:0]   op_val [NUM_OPS];
    fwd_src_e          sel    [NUM_OPS];
    logic [NUM_OPS-1:0] wait_op;

    assign rf_tag = '{wr: rf_reg_wr, dst: rf_ir[25:21], wdsel: rf_wdsel};

    assign src[0]    = rf_ir[20:16];
    assign src[1]    = rf_store_sel ? rf_ir[25:21] : rf_ir[15:11];
    assign rd_val[0] = rf_rd1;
    assign rd_val[1] = rf_rd2;

    hz_tag_pipe u_tags (
        .clk     (clk),
        .rst     (rst),
        .stall   (stall),
        .rf_tag  (rf_tag),
        .alu_tag (alu_tag),
        .mem_tag (mem_tag),
        .wb_tag  (wb_tag)
    );

    hz_stage_vals #(.XLEN(XLEN)) u_vals (
        .alu_tag (alu_tag),
        .mem_tag (mem_tag),
        .wb_tag  (wb_tag),
        .alu_pc4 (alu_pc4),
        .alu_res (alu_res),
        .mem_pc4 (mem_pc4),
        .mem_res (mem_res),
        .wb_pc4  (wb_pc4),
        .wb_res  (wb_res),
        .wb_mrd  (wb_mrd),
        .alu_fv  (alu_fv),
        .mem_fv  (mem_fv),
        .wb_fv   (wb_fv)
    );

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        hz_fwd_pick u_pick (
            .src       (src[g]),
            .alu_tag   (alu_tag),
            .mem_tag   (mem_tag),
            .wb_tag    (wb_tag),
            .sel       (sel[g]),
            .load_wait (wait_op[g])
        );

        assign op_val[g] = (sel[g] == FWD_ALU) ? alu_fv :
                           (sel[g] == FWD_MEM) ? mem_fv :
                           (sel[g] == FWD_WB)  ? wb_fv  : rd_val[g];
    end

    assign stall    = (|wait_op) & ~rst;
    assign sel_a    = sel[0];
    assign sel_b    = sel[1];
    assign op_a     = op_val[0];
    assign op_b     = op_val[1];
    assign wb_wdata = wb_fv;
    assign wb_we    = wb_tag.wr;
    assign wb_dst   = wb_tag.dst;

endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [25:11]    rf_ir,
    input logic            rf_store_sel,
    input logic            rf_reg_wr,
    input logic [1:0]      rf_wdsel,
    input logic            stall,
    input logic [1:0]      sel_a,
    input logic [1:0]      sel_b,
    input logic [XLEN-1:0] op_a,
    input logic [XLEN-1:0] wb_wdata
);

    // R10: no stall while reset is applied
    always_comb begin
        if (rst) begin
            p_stall_low_reset_r10: assert (!stall);
        end
    end

    // R2: register 31 never forwarded
    p_zero_reg_a_r2: assert property (@(posedge clk) disable iff (rst)
        (rf_ir[20:16] == 5'd31) |-> (sel_a == 2'd0));

    p_zero_reg_b_r2: assert property (@(posedge clk) disable iff (rst)
        (!rf_store_sel && rf_ir[15:11] == 5'd31) |-> (sel_b == 2'd0));

    // R6: write-back forwarding delivers the write data
    p_wb_fwd_value_r6: assert property (@(posedge clk) disable iff (rst)
        (sel_a == 2'd1) |-> (op_a == wb_wdata));

    // R7: a non-writer never becomes an execute-stage producer
    p_non_writer_r7: assert property (@(posedge clk) disable iff (rst)
        !rf_reg_wr |=> (sel_a != 2'd3 && sel_b != 2'd3));

    // R9: a stall puts a bubble into execute
    p_bubble_r9: assert property (@(posedge clk) disable iff (rst)
        stall |=> (sel_a != 2'd3 && sel_b != 2'd3));

    // R8: a load followed by a consumer of its destination stalls
    p_load_use_r8: assert property (@(posedge clk) disable iff (rst)
        (!stall && rf_reg_wr && rf_wdsel[1] && rf_ir[25:21] != 5'd31)
        |=> (rf_ir[20:16] != $past(rf_ir[25:21]) || stall));

endmodule

bind hazard_bypass_unit hz_checker #(.XLEN(XLEN)) u_hz_checker (
    .clk          (clk),
    .rst          (rst),
    .rf_ir        (rf_ir),
    .rf_store_sel (rf_store_sel),
    .rf_reg_wr    (rf_reg_wr),
    .rf_wdsel     (rf_wdsel),
    .stall        (stall),
    .sel_a        (sel_a),
    .sel_b        (sel_b),
    .op_a         (op_a),
    .wb_wdata     (wb_wdata)
);

// File: tb/tb_hazard_bypass_unit.sv
`timescale 1ns/1ps
module tb_hazard_bypass_unit;

    localparam int NCYC = 3000;

    logic        clk = 1'b0;
    logic        rst;
    logic [25:11] rf_ir;
    logic        rf_store_sel, rf_reg_wr;
    logic [1:0]  rf_wdsel;
    logic [31:0] rf_rd1, rf_rd2, alu_pc4, alu_res, mem_pc4, mem_res;
    logic [31:0] wb_pc4, wb_res, wb_mrd;
    logic        stall, wb_we;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] op_a, op_b, wb_wdata;
    logic [4:0]  wb_dst;

    always #2.5 clk = ~clk;

    hazard_bypass_unit dut (
        .clk(clk), .rst(rst), .rf_ir(rf_ir), .rf_store_sel(rf_store_sel),
        .rf_reg_wr(rf_reg_wr), .rf_wdsel(rf_wdsel), .rf_rd1(rf_rd1),
        .rf_rd2(rf_rd2), .alu_pc4(alu_pc4), .alu_res(alu_res),
        .mem_pc4(mem_pc4), .mem_res(mem_res), .wb_pc4(wb_pc4),
        .wb_res(wb_res), .wb_mrd(wb_mrd), .stall(stall), .sel_a(sel_a),
        .sel_b(sel_b), .op_a(op_a), .op_b(op_b), .wb_wdata(wb_wdata),
        .wb_we(wb_we), .wb_dst(wb_dst)
    );

    typedef struct {
        bit wr;
        int dst;
        int wd;
    } mrec_t;

    mrec_t flight[$];   // index 0 = execute, 1 = memory, 2 = write-back
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    task automatic chk(string what, string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic int pick_reg();
        int r = int'($urandom_range(0, 9));
        return (r < 8) ? (r % 4) : 31;
    endfunction

    function automatic mrec_t empty_rec();
        mrec_t e;
        e.wr = 0; e.dst = 0; e.wd = 0;
        return e;
    endfunction

    // Which stage supplies source s: 0 none, 1 wb, 2 mem, 3 exec
    function automatic int who(int s);
        if (s == 31) return 0;
        for (int i = 0; i < 3; i++)
            if (flight[i].wr && flight[i].dst == s) return 3 - i;
        return 0;
    endfunction

    function automatic logic [31:0] stage_val(int code, logic [31:0] rd, logic [31:0] wbv);
        case (code)
            3: return flight[0].wd[0] ? alu_res : alu_pc4;
            2: return flight[1].wd[0] ? mem_res : mem_pc4;
            1: return wbv;
            default: return rd;
        endcase
    endfunction

    task automatic drive_random();
        rf_ir[25:21]  = 5'(pick_reg());
        rf_ir[20:16]  = 5'(pick_reg());
        rf_ir[15:11]  = 5'(pick_reg());
        rf_store_sel  = ($urandom_range(0, 9) < 3);
        rf_reg_wr     = ($urandom_range(0, 9) < 7);
        rf_wdsel      = 2'($urandom_range(0, 3));
        rf_rd1  = $urandom; rf_rd2  = $urandom;
        alu_pc4 = $urandom; alu_res = $urandom;
        mem_pc4 = $urandom; mem_res = $urandom;
        wb_pc4  = $urandom; wb_res  = $urandom; wb_mrd = $urandom;
    endtask

    task automatic check_cycle();
        int sa, sb, ca, cb, srcb;
        bit exp_stall;
        logic [31:0] wbv;
        mrec_t nr;
        sa   = int'(rf_ir[20:16]);
        srcb = rf_store_sel ? int'(rf_ir[25:21]) : int'(rf_ir[15:11]);   // R1
        ca = who(sa);
        cb = who(srcb);
        case (flight[2].wd)
            0: wbv = wb_pc4;
            1: wbv = wb_res;
            2: wbv = wb_mrd;
            default: wbv = 32'h0;
        endcase
        exp_stall = !rst && (((ca == 3) && flight[0].wd[1]) || ((ca == 2) && flight[1].wd[1]) ||
                             ((cb == 3) && flight[0].wd[1]) || ((cb == 2) && flight[1].wd[1]));
        sb = srcb;
        if (sb == 31 || sa == 31) begin end
        chk("sel_a", "R1 R2 R3 R4 R9", {30'd0, sel_a}, ca);
        chk("sel_b", "R1 R2 R3 R4 R9", {30'd0, sel_b}, cb);
        chk("op_a", "R3 R5", op_a, stage_val(ca, rf_rd1, wbv));
        chk("op_b", "R3 R5", op_b, stage_val(cb, rf_rd2, wbv));
        chk("wb_wdata", "R6", wb_wdata, wbv);
        chk("wb_we", "R7", {31'd0, wb_we}, flight[2].wr);
        if (flight[2].wr)
            chk("wb_dst", "R7", {27'd0, wb_dst}, flight[2].dst);
        chk("stall", rst ? "R10" : "R8 R2", {31'd0, stall}, exp_stall);
        // advance the model as the next clock edge will
        if (rst) begin
            flight = '{empty_rec(), empty_rec(), empty_rec()};
        end else begin
            nr = empty_rec();
            if (rf_reg_wr && !exp_stall) begin
                nr.wr = 1; nr.dst = int'(rf_ir[25:21]); nr.wd = int'(rf_wdsel);
            end
            flight.push_front(nr);
            void'(flight.pop_back());
        end
    endtask

    initial begin
        flight = '{empty_rec(), empty_rec(), empty_rec()};
        rst = 1'b1;
        drive_random();
        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            rst = (c < 3) || (c >= 1500 && c < 1502);   // R10 mid-run reset
            drive_random();
            #1;
            check_cycle();
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(NCYC * 5 * 2 + 1000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule